// File: doc/BRIEF.md
# Chroma Decimation and Expansion Unit

This unit sits on a pixel stream between a video source or sink and a strip buffer. Each valid input beat carries one pixel: a luma sample and a pair of chroma samples (U and V), plus markers for the start of a frame and the start of a line. In compress direction the unit drops chroma according to one of four sampling modes. It flags the beats whose chroma is kept, so that a downstream writer can pack them. Luma is never touched. In expand direction the unit rebuilds full-rate chroma by pure replication. The last kept sample on a line is repeated across the positions that follow it. In the line-alternating mode, the chroma of the first line of each pair is replayed for the second line from an internal one-line store.

The mode select and the direction bit are captured on the frame-start beat and held for the whole frame. A line-control state machine tracks the frame. It has three states. ST_IDLE means no frame has started yet. ST_KEEP means the current line carries chroma. ST_DROP means the current line is the chroma-less second line of a pair, which happens only in the line-alternating mode. The transitions are as follows. Any state goes to ST_KEEP on a frame-start beat. On a line-start beat, ST_KEEP goes to ST_DROP when the frame's mode is 2, and ST_DROP returns to ST_KEEP. In all other modes a line-start beat leaves the machine in ST_KEEP. Without a marker, the state holds.

A pixel position counter restarts at each line start and saturates at MAX_W-1. Every output is registered, one clock after its input beat.

Top module: `cdx_chroma_resampler`

## Requirements
- R1: While reset is held and right after it, out_valid and out_c_valid are 0.
- R2: Valid beats before the first frame-start beat produce no output (out_valid stays 0).
- R3: For each valid beat after the first frame start, out_valid is 1 one clock later and out_y equals that beat's luma. A beat with in_valid=0 gives out_valid=0 one clock later.
- R4: Compress, mode 0 (luma only): out_c_valid=0 and out_u=out_v=0 on every beat.
- R5: Compress, mode 1: out_c_valid=1 exactly at even pixel positions (0,2,4,...), with out_u/out_v equal to the input chroma. Elsewhere out_c_valid=0 and out_u=out_v=0.
- R6: Compress, mode 3: chroma is kept only at positions divisible by four (0,4,8,...). Otherwise the output behaves as in R5.
- R7: Compress, mode 2: lines with even index within the frame (0-based, counted from the frame-start line) behave as in mode 1. Lines with odd index give out_c_valid=0 on every beat.
- R8: Expand, modes 1 and 3: out_c_valid=1 on every beat. At kept positions (the even positions for mode 1, positions divisible by four for mode 3) out_u/out_v equal the input. At other positions they repeat the last kept value of the line, and input chroma there has no effect.
- R9: Expand, mode 2: even-index lines behave as mode 1 of R8. On each odd-index line, out_u/out_v at position x equal the output chroma of the previous line at position x, and the input chroma has no effect.
- R10: Expand, mode 0: out_c_valid=0 and out_u=out_v=2^(W-1) (mid-scale).
- R11: Changes on mode_sel and dir_expand take effect only at the next frame-start beat.
- R12: The pixel position is 0 on any beat that carries a line-start or frame-start marker and rises by one on each further valid beat of the line. Invalid beats do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Beat is first pixel of a frame (implies line start) |
| in_sol | input | 1 | Beat is first pixel of a line |
| in_y | input | W | Luma sample |
| in_u | input | W | U chroma sample |
| in_v | input | W | V chroma sample |
| mode_sel | input | 2 | Sampling mode 0..3, captured at frame start |
| dir_expand | input | 1 | 0 = compress, 1 = expand, captured at frame start |
| out_valid | output | 1 | Output beat valid |
| out_y | output | W | Luma, unchanged |
| out_u | output | W | U chroma |
| out_v | output | W | V chroma |
| out_c_valid | output | 1 | Chroma present on this beat |

## Verification
The bench builds the unit with W=8 and MAX_W=16. With the store that small, a line can run the full store width, so the last store address and the counter's top value are both reached in replicated lines. Line widths of 5, 12 and 16 appear, with gaps inside lines. Together they cover mode 3 groups that end part-way through a line and odd line lengths in mode 2.

// File: rtl/cdx_pkg.sv
package cdx_pkg;

    typedef enum logic [1:0] {
        MODE_LUMA     = 2'd0,
        MODE_HALF     = 2'd1,
        MODE_HALF_ALT = 2'd2,
        MODE_QUARTER  = 2'd3
    } cdx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KEEP = 2'd1,
        ST_DROP = 2'd2
    } line_state_e;

endpackage

// File: rtl/cdx_line_ctrl.sv
module cdx_line_ctrl
    import cdx_pkg::*;
#(
    parameter int MAX_W = 64,
    localparam int XW = (MAX_W > 4) ? $clog2(MAX_W) : 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_sof,
    input  logic            in_sol,
    input  logic [1:0]      mode_sel,
    input  logic            dir_expand,
    output logic            pix_go,
    output logic [XW-1:0]   pix_x,
    output logic            pix_drop,
    output cdx_mode_e       pix_mode,
    output logic            pix_dir,
    output logic            st_idle
);

    localparam logic [XW-1:0] X_LAST = XW'(MAX_W - 1);

    line_state_e state_q, state_d;
    cdx_mode_e   mode_q;
    logic        dir_q;
    logic [XW-1:0] x_q;
    logic        frame_mark, line_mark;

    assign frame_mark = in_valid && in_sof;
    assign line_mark  = in_valid && (in_sol || in_sof);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (frame_mark) begin
            state_d = ST_KEEP;
        end else if (line_mark) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_KEEP: state_d = (mode_q == MODE_HALF_ALT) ? ST_DROP : ST_KEEP;
                ST_DROP: state_d = ST_KEEP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // per-beat outputs: the beat is judged by the state it opens
    always_comb begin
        pix_go   = in_valid && (state_d != ST_IDLE);
        pix_drop = (state_d == ST_DROP);
        pix_mode = frame_mark ? cdx_mode_e'(mode_sel) : mode_q;
        pix_dir  = frame_mark ? dir_expand : dir_q;
        pix_x    = line_mark ? '0 : x_q;
        st_idle  = (state_q == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_LUMA;
            dir_q  <= 1'b0;
            x_q    <= '0;
        end else begin
            if (frame_mark) begin
                mode_q <= cdx_mode_e'(mode_sel);
                dir_q  <= dir_expand;
            end
            if (in_valid) begin
                x_q <= (pix_x == X_LAST) ? pix_x : pix_x + 1'b1;
            end
        end
    end

    // R11: the captured mode only changes on a frame-start beat
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_mark |=> $stable(mode_q) && $stable(dir_q));

    // R12: a marked beat leaves the position at one for the next beat
    a_r12_x_restart: assert property (@(posedge clk) disable iff (!rst_n)
        line_mark |=> (x_q == XW'(1)));

    // R2: without a frame start the machine stays idle
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !frame_mark |=> (state_q == ST_IDLE));

endmodule

// File: rtl/cdx_line_store.sv
module cdx_line_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 4) ? $clog2(DEPTH) : 2
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cdx_sample_path.sv
module cdx_sample_path
    import cdx_pkg::*;
#(
    parameter int W     = 8,
    parameter int MAX_W = 64,
    localparam int XW = (MAX_W > 4) ? $clog2(MAX_W) : 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pix_go,
    input  logic [XW-1:0]   pix_x,
    input  logic            pix_drop,
    input  cdx_mode_e       pix_mode,
    input  logic            pix_dir,
    input  logic [W-1:0]    in_y,
    input  logic [W-1:0]    in_u,
    input  logic [W-1:0]    in_v,
    input  logic [2*W-1:0]  st_rd_data,
    output logic            st_wr_en,
    output logic [XW-1:0]   st_addr,
    output logic [2*W-1:0]  st_wr_data,
    output logic            out_valid,
    output logic [W-1:0]    out_y,
    output logic [W-1:0]    out_u,
    output logic [W-1:0]    out_v,
    output logic            out_c_valid
);

    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    logic [W-1:0] hold_u, hold_v;
    logic         keep_pos, c_take;
    logic [W-1:0] nxt_u, nxt_v;
    logic         nxt_cv;
    logic [W-1:0] rep_u, rep_v;

    always_comb begin
        unique case (pix_mode)
            MODE_HALF, MODE_HALF_ALT: keep_pos = (pix_x[0] == 1'b0);
            MODE_QUARTER:             keep_pos = (pix_x[1:0] == 2'b00);
            default:                  keep_pos = 1'b0;
        endcase
        c_take = (pix_mode != MODE_LUMA) && !pix_drop && keep_pos;
        rep_u  = keep_pos ? in_u : hold_u;
        rep_v  = keep_pos ? in_v : hold_v;
    end

    always_comb begin
        if (!pix_dir) begin
            nxt_cv = c_take;
            nxt_u  = c_take ? in_u : '0;
            nxt_v  = c_take ? in_v : '0;
        end else if (pix_mode == MODE_LUMA) begin
            nxt_cv = 1'b0;
            nxt_u  = MID;
            nxt_v  = MID;
        end else if (pix_drop) begin
            nxt_cv = 1'b1;
            nxt_u  = st_rd_data[2*W-1:W];
            nxt_v  = st_rd_data[W-1:0];
        end else begin
            nxt_cv = 1'b1;
            nxt_u  = rep_u;
            nxt_v  = rep_v;
        end
    end

    assign st_addr    = pix_x;
    assign st_wr_en   = pix_go && pix_dir && (pix_mode == MODE_HALF_ALT) && !pix_drop;
    assign st_wr_data = {rep_u, rep_v};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_u      <= '0;
            hold_v      <= '0;
            out_valid   <= 1'b0;
            out_c_valid <= 1'b0;
            out_y       <= '0;
            out_u       <= '0;
            out_v       <= '0;
        end else begin
            if (pix_go && pix_dir && !pix_drop && keep_pos) begin
                hold_u <= in_u;
                hold_v <= in_v;
            end
            out_valid   <= pix_go;
            out_c_valid <= pix_go && nxt_cv;
            if (pix_go) begin
                out_y <= in_y;
                out_u <= nxt_u;
                out_v <= nxt_v;
            end
        end
    end

    // R4: luma-only compress never flags chroma
    a_r4_luma_no_chroma: assert property (@(posedge clk) disable iff (!rst_n)
        pix_go && !pix_dir && (pix_mode == MODE_LUMA) |=> !out_c_valid);

    // R7: second line of a pair carries no chroma in compress
    a_r7_drop_line_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pix_go && !pix_dir && pix_drop |=> !out_c_valid);

    // R8: expand with chroma modes yields chroma on every beat
    a_r8_expand_full: assert property (@(posedge clk) disable iff (!rst_n)
        pix_go && pix_dir && (pix_mode != MODE_LUMA) |=> out_c_valid);

    // R3: output beat follows accepted input beat
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pix_go |=> out_valid && (out_y == $past(in_y)));

endmodule

// File: rtl/cdx_chroma_resampler.sv
module cdx_chroma_resampler
    import cdx_pkg::*;
#(
    parameter int W     = 8,
    parameter int MAX_W = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    input  logic [W-1:0]  in_y,
    input  logic [W-1:0]  in_u,
    input  logic [W-1:0]  in_v,
    input  logic [1:0]    mode_sel,
    input  logic          dir_expand,
    output logic          out_valid,
    output logic [W-1:0]  out_y,
    output logic [W-1:0]  out_u,
    output logic [W-1:0]  out_v,
    output logic          out_c_valid
);

    localparam int XW = (MAX_W > 4) ? $clog2(MAX_W) : 2;

    logic            pix_go, pix_drop, pix_dir, st_idle;
    logic [XW-1:0]   pix_x, st_addr;
    cdx_mode_e       pix_mode;
    logic            st_wr_en;
    logic [2*W-1:0]  st_wr_data, st_rd_data;

    cdx_line_ctrl #(.MAX_W(MAX_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_sol     (in_sol),
        .mode_sel   (mode_sel),
        .dir_expand (dir_expand),
        .pix_go     (pix_go),
        .pix_x      (pix_x),
        .pix_drop   (pix_drop),
        .pix_mode   (pix_mode),
        .pix_dir    (pix_dir),
        .st_idle    (st_idle)
    );

    cdx_line_store #(.DW(2*W), .DEPTH(MAX_W)) store_i (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_addr (st_addr),
        .wr_data (st_wr_data),
        .rd_addr (st_addr),
        .rd_data (st_rd_data)
    );

    cdx_sample_path #(.W(W), .MAX_W(MAX_W)) path_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_go      (pix_go),
        .pix_x       (pix_x),
        .pix_drop    (pix_drop),
        .pix_mode    (pix_mode),
        .pix_dir     (pix_dir),
        .in_y        (in_y),
        .in_u        (in_u),
        .in_v        (in_v),
        .st_rd_data  (st_rd_data),
        .st_wr_en    (st_wr_en),
        .st_addr     (st_addr),
        .st_wr_data  (st_wr_data),
        .out_valid   (out_valid),
        .out_y       (out_y),
        .out_u       (out_u),
        .out_v       (out_v),
        .out_c_valid (out_c_valid)
    );

    // R2: no output while no frame has begun
    a_r2_no_early_out: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle && !(in_valid && in_sof) |=> !out_valid);

    // R3: an empty input beat gives an empty output beat
    a_r3_gap_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_c_valid);

endmodule

// File: tb/cdx_chroma_resampler_tb_top.sv
module cdx_chroma_resampler_tb_top;

    localparam int W     = 8;
    localparam int MAX_W = 16;
    localparam logic [W-1:0] MID = 8'h80;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_sof, in_sol, dir_expand;
    logic [W-1:0] in_y, in_u, in_v;
    logic [1:0] mode_sel;
    logic out_valid, out_c_valid;
    logic [W-1:0] out_y, out_u, out_v;

    always #2.5 clk = ~clk;

    cdx_chroma_resampler #(.W(W), .MAX_W(MAX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_y(in_y), .in_u(in_u), .in_v(in_v),
        .mode_sel(mode_sel), .dir_expand(dir_expand), .out_valid(out_valid),
        .out_y(out_y), .out_u(out_u), .out_v(out_v), .out_c_valid(out_c_valid)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // reference model state
    bit      m_started = 0;
    int      m_mode = 0;
    bit      m_dir = 0;
    int      m_line = 0;
    int      m_x = 0;
    int      m_hold_u = 0, m_hold_v = 0;
    int      m_prev_u [MAX_W];
    int      m_prev_v [MAX_W];
    string   tag_override = "";

    bit      e_valid = 0, e_cv = 0;
    int      e_y = 0, e_u = 0, e_v = 0;
    string   e_tag = "R1";

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(bit started, bit dir, int mode);
        if (!started) return "R2";
        if (!dir) begin
            case (mode)
                0: return "R4";
                1: return "R5";
                2: return "R7";
                default: return "R6";
            endcase
        end
        case (mode)
            0: return "R10";
            2: return "R9";
            default: return "R8";
        endcase
    endfunction

    // one beat: check previous result, drive new inputs, advance model
    task automatic beat(bit v, bit sof, bit sol, int y, int u, int c);
        bit kp, drop;
        @(negedge clk);
        check(e_tag, "out_valid", int'(out_valid), int'(e_valid));
        if (e_valid) begin
            check("R3", "out_y", int'(out_y), e_y);
            check(e_tag, "out_c_valid", int'(out_c_valid), int'(e_cv));
            check(e_tag, "out_u", int'(out_u), e_u);
            check(e_tag, "out_v", int'(out_v), e_v);
        end
        in_valid = v; in_sof = sof; in_sol = sol;
        in_y = W'(y); in_u = W'(u); in_v = W'(c);
        e_valid = 0; e_cv = 0;
        if (v) begin
            if (sof) begin
                m_started = 1; m_mode = int'(mode_sel); m_dir = dir_expand;
                m_line = 0; m_x = 0;
            end else if (sol) begin
                m_line++; m_x = 0;
            end
            e_tag = (tag_override != "") ? tag_override : mode_tag(m_started, m_dir, m_mode);
            if (m_started) begin
                drop = (m_mode == 2) && (m_line % 2 == 1);
                kp = (m_mode == 3) ? (m_x % 4 == 0) : (m_x % 2 == 0);
                e_valid = 1;
                e_y = y & 255;
                if (!m_dir) begin
                    e_cv = (m_mode != 0) && !drop && kp;
                    e_u = e_cv ? (u & 255) : 0;
                    e_v = e_cv ? (c & 255) : 0;
                end else if (m_mode == 0) begin
                    e_cv = 0; e_u = MID; e_v = MID;
                end else if (drop) begin
                    e_cv = 1; e_u = m_prev_u[m_x]; e_v = m_prev_v[m_x];
                end else begin
                    if (kp) begin m_hold_u = u & 255; m_hold_v = c & 255; end
                    e_cv = 1; e_u = m_hold_u; e_v = m_hold_v;
                    m_prev_u[m_x] = m_hold_u; m_prev_v[m_x] = m_hold_v;
                end
            end
            if (m_x < MAX_W - 1) m_x++;
        end else begin
            e_tag = (tag_override != "") ? tag_override : "R3";
        end
    endtask

    task automatic send_line(bit sof, int n, int seed, bit gaps);
        for (int i = 0; i < n; i++) begin
            beat(1, sof && i == 0, i == 0, seed + i * 5, seed * 3 + i * 7 + 1, seed + i * 11 + 2);
            if (gaps && (i % 3 == 1)) beat(0, 0, 0, 0, 99, 99);
        end
    endtask

    task automatic send_frame(int m, bit d, int lines, int n, int seed, bit gaps);
        mode_sel = 2'(m); dir_expand = d;
        for (int l = 0; l < lines; l++) send_line(l == 0, n, seed + l * 17, gaps);
        beat(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst_n = 0; in_valid = 0; in_sof = 0; in_sol = 0;
        in_y = 0; in_u = 0; in_v = 0; mode_sel = 1; dir_expand = 0;
        for (int i = 0; i < MAX_W; i++) begin m_prev_u[i] = 0; m_prev_v[i] = 0; end
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_c_valid in reset", int'(out_c_valid), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "out_c_valid after reset", int'(out_c_valid), 0);
        // R2: beats before any frame start, including line markers
        send_line(0, 6, 3, 0);
        // compress, all modes
        send_frame(1, 0, 2, 12, 10, 0);
        send_frame(3, 0, 2, 12, 20, 1);
        send_frame(0, 0, 2, 9, 30, 0);
        send_frame(2, 0, 4, 12, 40, 1);
        // R11: mode and direction change in mid-frame are not applied
        mode_sel = 2; dir_expand = 0;
        tag_override = "R11";
        send_line(1, 8, 50, 0);
        mode_sel = 1; dir_expand = 1;
        send_line(0, 8, 51, 0);
        send_line(0, 8, 52, 0);
        tag_override = "";
        beat(0, 0, 0, 0, 0, 0);
        // expand, all modes
        send_frame(1, 1, 2, 12, 60, 1);
        send_frame(3, 1, 2, 11, 70, 0);
        send_frame(2, 1, 4, 12, 80, 1);
        send_frame(2, 1, 2, 16, 90, 0);
        send_frame(0, 1, 2, 7, 100, 0);
        // R12: line lengths vary and lines butt directly
        tag_override = "R12";
        mode_sel = 3; dir_expand = 0;
        send_line(1, 5, 110, 0);
        send_line(0, 16, 111, 0);
        send_line(0, 3, 112, 1);
        mode_sel = 2; dir_expand = 1;
        send_line(1, 5, 120, 0);
        send_line(0, 5, 121, 0);
        send_line(0, 16, 122, 0);
        send_line(0, 16, 123, 1);
        tag_override = "";
        beat(0, 0, 0, 0, 0, 0);
        beat(0, 0, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected at most 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule